// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Register

This block carries a single 36-bit word from a writing clock domain to a reading clock domain without using the FIFO that runs alongside it. The writer posts a word on its own clock when it enables an access with the mailbox selected. A mail flag is active low while a word is waiting, and the reader watches this flag. The reader takes the word on its own clock with an enabled, mailbox-selected access. That access clears the flag.

The flag is kept in the reader's domain. Each accepted write flips a toggle, and a synchronizer carries that toggle across to the reader. When the reader collects the word it flips an acknowledge toggle, and a second synchronizer carries that one back to the writer. The writer accepts a new word only once its synchronized view of the acknowledge matches its own toggle. Until then, any write is dropped and is never queued. The stored word therefore stays still for as long as the reader can see it.

The block also contains the reader-side output selector. It presents the mailbox word when the mailbox is selected and the FIFO output-register word when it is not. A single asynchronous active-low reset stands for the reset of the associated FIFO. It clears the flag in both domains.

Top module: `mbx_bypass`

## Requirements
- R1: While reset is applied and right after it, mail_flag_n is 1 (no mail) and a write posted after reset is accepted.
- R2: A writer access with wr_en=1 and wr_mb_sel=1 while the mailbox is open stores wr_data. mail_flag_n goes to 0 within SYNC_STAGES+1 rising rd_clk edges after the storing wr_clk edge.
- R3: While a word is waiting, writer accesses are dropped, and the stored word is not changed.
- R4: A write issued after the reader's clearing read, but before that read's acknowledge has crossed back to the writer, is dropped. mail_flag_n stays 1.
- R5: A reader access with rd_en=1 and rd_mb_sel=1 while mail_flag_n=0 sets mail_flag_n to 1 right after that rd_clk edge.
- R6: A reader access with rd_mb_sel=0, or with rd_en=0, leaves mail_flag_n at 0.
- R7: A writer access with wr_mb_sel=0 or wr_en=0 stores nothing, and mail_flag_n stays 1.
- R8: rd_dout equals the mailbox word when rd_mb_sel=1 and equals fifo_dout when rd_mb_sel=0.
- R9: Reset applied while mail is waiting returns mail_flag_n to 1 and reopens writes.
- R10: A mailbox-selected read while no mail waits changes nothing. The next write still sets mail_flag_n to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer-domain clock |
| rd_clk | input | 1 | Reader-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset (FIFO reset) |
| wr_en | input | 1 | Writer access enable |
| wr_mb_sel | input | 1 | Writer selects the mailbox |
| wr_data | input | DATA_W (36) | Word to post |
| rd_en | input | 1 | Reader access enable |
| rd_mb_sel | input | 1 | Reader selects the mailbox rather than the FIFO |
| fifo_dout | input | DATA_W (36) | FIFO output-register word |
| rd_dout | output | DATA_W (36) | Selected read word |
| mail_flag_n | output | 1 | 0 while mail waits for the reader |

## Verification
The bench runs the two clocks at unrelated periods. It targets the window between the reader's clearing read and the return of the acknowledge. A design that reopened writes too early, or that queued the blocked write, would show the flag falling again without a new post. The bench also overwrites attempts while mail waits. A design that let those through would return the later word instead of the first. Reads with either the select or the enable low must not clear the flag, and a read with no mail waiting must not flip the acknowledge. If it did, the toggles would fall out of step, and the next post would be either lost or shown as mail twice.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned MBX_DATA_W_DEF  = 36;
   localparam int unsigned MBX_SYNC_MIN    = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < mbx_pkg::MBX_SYNC_MIN) begin : g_bad
         $error("mbx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side #(
   parameter int unsigned DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sel,
   input  logic [DATA_W-1:0] din,
   input  logic              ack_s,
   output logic              post_tog,
   output logic [DATA_W-1:0] mail_q
);
   logic open;
   logic accept;

   assign open   = (post_tog == ack_s);
   assign accept = en && sel && open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         post_tog <= 1'b0;
         mail_q   <= '0;
      end else if (accept) begin
         post_tog <= ~post_tog;
         mail_q   <= din;
      end
   end

   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(mail_q));
   // R3
   busy_no_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(post_tog));
   // R7
   unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && sel) |=> $stable(post_tog));
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sel,
   input  logic post_s,
   output logic ack_tog,
   output logic flag_n
);
   logic pending;
   logic take;

   assign pending = post_s ^ ack_tog;
   assign take    = en && sel && pending;
   assign flag_n  = ~pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ack_tog <= 1'b0;
      else if (take) ack_tog <= ~ack_tog;
   end

   // R5
   clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> flag_n);
   // R6
   hold_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !(en && sel)) |=> !flag_n);
   // R10
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |=> $stable(ack_tog));
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass #(
   parameter int unsigned DATA_W      = mbx_pkg::MBX_DATA_W_DEF,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_mb_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_mb_sel,
   input  logic [DATA_W-1:0] fifo_dout,
   output logic [DATA_W-1:0] rd_dout,
   output logic              mail_flag_n
);
   logic              post_tog, post_s;
   logic              ack_tog, ack_s;
   logic [DATA_W-1:0] mail_q;

   mbx_wr_side #(.DATA_W(DATA_W)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .en(wr_en), .sel(wr_mb_sel),
      .din(wr_data), .ack_s(ack_s), .post_tog(post_tog), .mail_q(mail_q));

   mbx_sync #(.STAGES(SYNC_STAGES)) u_post_sync (
      .clk(rd_clk), .rst_n(rst_n), .d(post_tog), .q(post_s));

   mbx_rd_side u_rd (
      .clk(rd_clk), .rst_n(rst_n), .en(rd_en), .sel(rd_mb_sel),
      .post_s(post_s), .ack_tog(ack_tog), .flag_n(mail_flag_n));

   mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(wr_clk), .rst_n(rst_n), .d(ack_tog), .q(ack_s));

   assign rd_dout = rd_mb_sel ? mail_q : fifo_dout;

   // R8
   mux_sel_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_mb_sel |-> (rd_dout == fifo_dout));
endmodule

// File: tb/sim_mbx_bypass.sv
module sim_mbx_bypass;
   localparam int W = 36;
   logic wr_clk = 0, rd_clk = 0, rst_n = 0;
   logic wr_en = 0, wr_mb_sel = 0, rd_en = 0, rd_mb_sel = 0;
   logic [W-1:0] wr_data = '0, fifo_dout = '0;
   logic [W-1:0] rd_dout;
   logic mail_flag_n;
   int tests = 0, fails = 0;
   int cyc = 0;

   always #2.5 wr_clk = ~wr_clk;
   always #3.5 rd_clk = ~rd_clk;

   mbx_bypass #(.DATA_W(W)) u0 (.*);

   always @(posedge wr_clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(negedge rd_clk);
      rst_n = 1;
      repeat (2) @(negedge rd_clk);
   endtask

   task automatic post(logic [W-1:0] d, logic en = 1, logic sel = 1);
      @(negedge wr_clk);
      wr_en = en; wr_mb_sel = sel; wr_data = d;
      @(negedge wr_clk);
      wr_en = 0; wr_mb_sel = 0;
   endtask

   task automatic rd_mail(output logic [W-1:0] d, input logic en = 1, input logic sel = 1);
      @(negedge rd_clk);
      rd_en = en; rd_mb_sel = sel;
      #1 d = rd_dout;
      @(negedge rd_clk);
      rd_en = 0; rd_mb_sel = 0;
   endtask

   task automatic settle();
      repeat (4) @(negedge rd_clk);
   endtask

   task automatic t_reset();
      rst_n = 0;
      #1 chk("R1 flag in reset", mail_flag_n, 1);
      do_reset();
      chk("R1 flag after reset", mail_flag_n, 1);
      post(36'h1_2345_6789);
      settle();
      chk("R1 post after reset accepted", mail_flag_n, 0);
   endtask

   task automatic t_post_latency();
      logic [W-1:0] d;
      do_reset();
      post(36'hA_AAAA_5555);
      @(negedge rd_clk);
      repeat (3) @(negedge rd_clk);
      chk("R2 flag low within window", mail_flag_n, 0);
      rd_mail(d);
      chk("R2 word stored", d, 36'hA_AAAA_5555);
      chk("R5 flag high after read", mail_flag_n, 1);
   endtask

   task automatic t_blocked();
      logic [W-1:0] d;
      do_reset();
      post(36'h0_0000_0011);
      settle();
      post(36'h0_0000_0022);
      post(36'hF_FFFF_FFFF);
      rd_mail(d);
      chk("R3 first word kept", d, 36'h0_0000_0011);
      settle(); settle();
      chk("R3 blocked write not queued", mail_flag_n, 1);
   endtask

   task automatic t_early_write();
      logic [W-1:0] d;
      do_reset();
      post(36'h3_3333_3333);
      settle();
      rd_mail(d);
      post(36'h4_4444_4444);
      settle(); settle();
      chk("R4 early write dropped", mail_flag_n, 1);
      post(36'h5_5555_5555);
      settle();
      chk("R4 writes reopen later", mail_flag_n, 0);
      rd_mail(d);
      chk("R4 later word", d, 36'h5_5555_5555);
   endtask

   task automatic t_no_clear();
      logic [W-1:0] d;
      do_reset();
      post(36'h6_0000_0006);
      settle();
      rd_mail(d, 1, 0);
      chk("R6 sel low keeps flag", mail_flag_n, 0);
      rd_mail(d, 0, 1);
      chk("R6 en low keeps flag", mail_flag_n, 0);
      rd_mail(d);
      chk("R6 word after ignored reads", d, 36'h6_0000_0006);
   endtask

   task automatic t_wr_ignored();
      logic [W-1:0] d;
      do_reset();
      post(36'h7_0000_0007, 1, 0);
      post(36'h7_0000_0008, 0, 1);
      settle();
      chk("R7 unselected write ignored", mail_flag_n, 1);
      @(negedge rd_clk); rd_mb_sel = 1; #1 d = rd_dout; rd_mb_sel = 0;
      chk("R7 mailbox word unchanged", d, 36'h0);
   endtask

   task automatic t_mux();
      logic [W-1:0] d;
      do_reset();
      post(36'h8_1234_0008);
      settle();
      fifo_dout = 36'hC_0FFE_E00C;
      @(negedge rd_clk); rd_en = 1; rd_mb_sel = 0; #1 d = rd_dout;
      chk("R8 fifo word when sel low", d, 36'hC_0FFE_E00C);
      rd_en = 0; rd_mb_sel = 1; #1 d = rd_dout;
      chk("R8 mail word when sel high", d, 36'h8_1234_0008);
      rd_mb_sel = 0;
   endtask

   task automatic t_reset_pending();
      do_reset();
      post(36'h9_9999_9999);
      settle();
      chk("R9 flag low before reset", mail_flag_n, 0);
      do_reset();
      chk("R9 flag high after reset", mail_flag_n, 1);
      post(36'h9_0000_0001);
      settle();
      chk("R9 writes reopen", mail_flag_n, 0);
   endtask

   task automatic t_idle_read();
      logic [W-1:0] d;
      do_reset();
      rd_mail(d);
      settle();
      chk("R10 flag after idle read", mail_flag_n, 1);
      post(36'hB_0000_000B);
      settle();
      chk("R10 post after idle read", mail_flag_n, 0);
      rd_mail(d);
      chk("R10 word", d, 36'hB_0000_000B);
   endtask

   initial begin
      t_reset();
      t_post_latency();
      t_blocked();
      t_early_write();
      t_no_clear();
      t_wr_ignored();
      t_mux();
      t_reset_pending();
      t_idle_read();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule